// File: doc/BRIEF.md
# I2C Message Transaction Sequencer

This block drives a byte-oriented I2C master core through a whole transaction made of several messages. Each message is described by a 7-bit target address, a read/write direction, a flag that skips the address phase, a flag that flips the direction bit on the wire, and a byte count. The sequencer fetches the current message descriptor by index and walks through it. It builds and sends the address byte with START, retrying failed addressing after a bus recovery. It then streams data bytes from or into a byte buffer port. A STOP is issued only on the very last byte of the final message.

The core is commanded with one-cycle command pulses and reports a transfer-in-progress flag, a slave-acknowledge flag, an arbitration-lost flag and a received byte. After every command the sequencer waits for transfer-in-progress to drop before it issues the next one, and a programmable poll limit catches a stuck core. Errors lead to a recovery write: START, the byte 0x00 and STOP in one command. A plain STOP is not used because its timing on the core is unreliable. The outcome is reported as a status code and a message index, together with a done pulse.

Top module: `i2cs_seq`

## Requirements
- R1: The address byte equals {addr7, dir}, where dir is 1 for a read, and dir is inverted when the message's reverse-direction flag is set.
- R2: A message with the skip-address flag issues no address command; its first data byte is sent without START.
- R3: An address command carries START and no STOP. If it fails (slave ACK missing, core_rxack=1, or arbitration lost), a recovery command follows. Addressing is tried at most 3 times in total. After the third failure the status becomes IO error (2'd1), with one recovery after each failed attempt.
- R4: A recovery command is a write carrying START and STOP with data byte 0x00.
- R5: Data commands never carry START. STOP is set only on the last data byte of the last message (index msg_count-1).
- R6: In a read message, every byte except the last is acknowledged (cmd_nack=0) and the last is sent with cmd_nack=1. Each received byte is presented once on buf_rdata with buf_rwe=1 and its byte position on buf_pos.
- R7: A command is never issued while core_tip is high, and every command has exactly one of cmd_rd or cmd_wr set.
- R8: On a write data byte, core_rxack=1 or core_al=1 aborts the transaction. On a read byte, only core_al aborts and core_rxack is ignored. An abort issues exactly one recovery command and then ends with status IO error (2'd1).
- R9: If core_tip is still high after tmo_limit poll cycles, the transaction ends at once with status timeout (2'd2) and no further command.
- R10: After reset, busy, done and cmd_valid are 0 and status is 0. A successful transaction ends with status OK (2'd0), result_idx = msg_count-1, busy=0 and a done pulse exactly one cycle long.
- R11: status and result_idx hold until the next accepted start. A start while busy is ignored and does not restart the transaction.
- R12: A message with length 0 sends only its address (or nothing when addressing is skipped) and moves on. If it is the last message, no STOP is issued at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| msg_count | input | MSG_W | Number of messages in the transaction |
| tmo_limit | input | TMO_W | Poll cycles allowed with core_tip high |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| status | output | 2 | 0 OK, 1 IO error, 2 timeout |
| result_idx | output | MSG_W | Last message index reached |
| desc_idx | output | MSG_W | Index of the message descriptor being used |
| desc_addr | input | 7 | Target address of the message |
| desc_read | input | 1 | Message reads from the target |
| desc_nostart | input | 1 | Skip the address phase |
| desc_revdir | input | 1 | Invert the direction bit of the address byte |
| desc_len | input | LEN_W | Data byte count |
| buf_pos | output | LEN_W | Byte position within the current message |
| buf_wdata | input | 8 | Byte to transmit at buf_pos |
| buf_rwe | output | 1 | Received byte valid |
| buf_rdata | output | 8 | Received byte |
| cmd_valid | output | 1 | Command pulse to the master core |
| cmd_sta | output | 1 | Generate START before the byte |
| cmd_sto | output | 1 | Generate STOP after the byte |
| cmd_rd | output | 1 | Read a byte |
| cmd_wr | output | 1 | Write a byte |
| cmd_nack | output | 1 | Do not acknowledge the read byte |
| cmd_byte | output | 8 | Byte to write |
| core_tip | input | 1 | Transfer in progress |
| core_rxack | input | 1 | 1 when the slave did not acknowledge |
| core_al | input | 1 | Arbitration lost |
| core_rdata | input | 8 | Byte received by the core |

## Verification
The bench targets the retry budget. A sequencer off by one would either give up after two address failures or send a fourth address, and the recovery count then differs. It checks that STOP appears only in the last message. A design keying STOP to every message end would close the bus between messages, and one ignoring zero length would STOP on a phantom byte. Read-side tolerance of a missing ACK is exercised next to arbitration loss, so a design treating reads like writes aborts a good read. A second start is pulsed mid-transaction; a design that accepted it would replay the address and produce extra commands and done pulses.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_MSG, S_ISSUE, S_ARM, S_POLL, S_STEP, S_ENDM
  } state_t;

  typedef enum logic [1:0] {
    K_ADDR, K_DATA, K_REC
  } kind_t;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_IO  = 2'd1,
    ST_TMO = 2'd2
  } status_t;
endpackage

// File: rtl/i2cs_addr_byte.sv
`timescale 1ns/1ps
module i2cs_addr_byte (
  input  logic [6:0] addr7,
  input  logic       rd,
  input  logic       rev,
  output logic [7:0] byte_o
);
  always_comb byte_o = {addr7, rd ^ rev};
endmodule

// File: rtl/i2cs_cmd_form.sv
`timescale 1ns/1ps
module i2cs_cmd_form
  import i2cs_pkg::*;
(
  input  kind_t      kind,
  input  logic [7:0] addr_byte,
  input  logic [7:0] wdata,
  input  logic       is_read,
  input  logic       last_byte,
  input  logic       last_msg,
  output logic       sta,
  output logic       sto,
  output logic       rd,
  output logic       wr,
  output logic       nack,
  output logic [7:0] data
);
  always_comb begin
    sta  = 1'b0;
    sto  = 1'b0;
    rd   = 1'b0;
    wr   = 1'b1;
    nack = 1'b0;
    data = 8'h00;
    case (kind)
      K_ADDR: begin
        sta  = 1'b1;
        data = addr_byte;
      end
      K_REC: begin
        sta = 1'b1;
        sto = 1'b1;
      end
      default: begin
        rd   = is_read;
        wr   = !is_read;
        sto  = last_byte && last_msg;
        nack = is_read && last_byte;
        data = is_read ? 8'h00 : wdata;
      end
    endcase
  end
endmodule

// File: rtl/i2cs_tip_timer.sv
`timescale 1ns/1ps
module i2cs_tip_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (tick && cnt != '1)
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/i2cs_seq.sv
`timescale 1ns/1ps
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int MSG_W      = 4,
  parameter int LEN_W      = 8,
  parameter int TMO_W      = 16,
  parameter int ADDR_TRIES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [MSG_W-1:0] msg_count,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic [MSG_W-1:0] result_idx,
  output logic [MSG_W-1:0] desc_idx,
  input  logic [6:0]       desc_addr,
  input  logic             desc_read,
  input  logic             desc_nostart,
  input  logic             desc_revdir,
  input  logic [LEN_W-1:0] desc_len,
  output logic [LEN_W-1:0] buf_pos,
  input  logic [7:0]       buf_wdata,
  output logic             buf_rwe,
  output logic [7:0]       buf_rdata,
  output logic             cmd_valid,
  output logic             cmd_sta,
  output logic             cmd_sto,
  output logic             cmd_rd,
  output logic             cmd_wr,
  output logic             cmd_nack,
  output logic [7:0]       cmd_byte,
  input  logic             core_tip,
  input  logic             core_rxack,
  input  logic             core_al,
  input  logic [7:0]       core_rdata
);
  localparam int TRY_W = $clog2(ADDR_TRIES + 1);

  state_t           st;
  kind_t            kind;
  logic [MSG_W-1:0] msg;
  logic [LEN_W-1:0] pos;
  logic [TRY_W-1:0] tries;
  logic             retry_q;

  logic       last_msg, last_byte, tmo_hit, xfer_bad;
  logic [7:0] addr_byte;
  logic       f_sta, f_sto, f_rd, f_wr, f_nack;
  logic [7:0] f_data;

  assign desc_idx  = msg;
  assign buf_pos   = pos;
  assign last_msg  = (msg == msg_count - 1'b1);
  assign last_byte = (pos == desc_len - 1'b1);

  i2cs_addr_byte u_addr (
    .addr7 (desc_addr),
    .rd    (desc_read),
    .rev   (desc_revdir),
    .byte_o(addr_byte)
  );

  i2cs_cmd_form u_form (
    .kind     (kind),
    .addr_byte(addr_byte),
    .wdata    (buf_wdata),
    .is_read  (desc_read),
    .last_byte(last_byte),
    .last_msg (last_msg),
    .sta      (f_sta),
    .sto      (f_sto),
    .rd       (f_rd),
    .wr       (f_wr),
    .nack     (f_nack),
    .data     (f_data)
  );

  i2cs_tip_timer #(.W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clear  (st != S_POLL),
    .tick   (st == S_POLL && core_tip),
    .limit  (tmo_limit),
    .expired(tmo_hit)
  );

  // Failure judgement per command kind: reads tolerate a missing ACK.
  always_comb begin
    case (kind)
      K_ADDR:  xfer_bad = core_rxack || core_al;
      K_DATA:  xfer_bad = desc_read ? core_al : (core_rxack || core_al);
      default: xfer_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind       <= K_ADDR;
      msg        <= '0;
      pos        <= '0;
      tries      <= '0;
      retry_q    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      status     <= ST_OK;
      result_idx <= '0;
      buf_rwe    <= 1'b0;
      buf_rdata  <= 8'h00;
      cmd_valid  <= 1'b0;
      cmd_sta    <= 1'b0;
      cmd_sto    <= 1'b0;
      cmd_rd     <= 1'b0;
      cmd_wr     <= 1'b0;
      cmd_nack   <= 1'b0;
      cmd_byte   <= 8'h00;
    end else begin
      done      <= 1'b0;
      cmd_valid <= 1'b0;
      buf_rwe   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            status <= ST_OK;
            msg    <= '0;
            if (msg_count == '0) begin
              done       <= 1'b1;
              result_idx <= '0;
            end else begin
              busy <= 1'b1;
              st   <= S_MSG;
            end
          end
        end
        S_MSG: begin
          pos   <= '0;
          tries <= '0;
          if (!desc_nostart) begin
            kind <= K_ADDR;
            st   <= S_ISSUE;
          end else if (desc_len == '0) begin
            st <= S_ENDM;
          end else begin
            kind <= K_DATA;
            st   <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          cmd_valid <= 1'b1;
          cmd_sta   <= f_sta;
          cmd_sto   <= f_sto;
          cmd_rd    <= f_rd;
          cmd_wr    <= f_wr;
          cmd_nack  <= f_nack;
          cmd_byte  <= f_data;
          st        <= S_ARM;
        end
        S_ARM: st <= S_POLL;
        S_POLL: begin
          if (core_tip) begin
            if (tmo_hit) begin
              st         <= S_IDLE;
              busy       <= 1'b0;
              done       <= 1'b1;
              status     <= ST_TMO;
              result_idx <= msg;
            end
          end else begin
            case (kind)
              K_ADDR: begin
                if (xfer_bad) begin
                  tries   <= tries + 1'b1;
                  retry_q <= (tries < TRY_W'(ADDR_TRIES - 1));
                  kind    <= K_REC;
                  st      <= S_ISSUE;
                end else if (desc_len == '0) begin
                  st <= S_ENDM;
                end else begin
                  kind <= K_DATA;
                  st   <= S_ISSUE;
                end
              end
              K_DATA: begin
                if (xfer_bad) begin
                  retry_q <= 1'b0;
                  kind    <= K_REC;
                  st      <= S_ISSUE;
                end else begin
                  if (desc_read) begin
                    buf_rwe   <= 1'b1;
                    buf_rdata <= core_rdata;
                  end
                  st <= S_STEP;
                end
              end
              default: begin
                if (retry_q) begin
                  kind <= K_ADDR;
                  st   <= S_ISSUE;
                end else begin
                  st         <= S_IDLE;
                  busy       <= 1'b0;
                  done       <= 1'b1;
                  status     <= ST_IO;
                  result_idx <= msg;
                end
              end
            endcase
          end
        end
        S_STEP: begin
          if (last_byte) begin
            st <= S_ENDM;
          end else begin
            pos <= pos + 1'b1;
            st  <= S_ISSUE;
          end
        end
        S_ENDM: begin
          if (last_msg) begin
            st         <= S_IDLE;
            busy       <= 1'b0;
            done       <= 1'b1;
            status     <= ST_OK;
            result_idx <= msg;
          end else begin
            msg <= msg + 1'b1;
            st  <= S_MSG;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_seq_chk.sv
`timescale 1ns/1ps
module i2cs_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       cmd_valid,
  input logic       cmd_sta,
  input logic       cmd_sto,
  input logic       cmd_rd,
  input logic       cmd_wr,
  input logic       cmd_nack,
  input logic [7:0] cmd_byte,
  input logic       core_tip
);
  a_r7_no_cmd_in_flight: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !core_tip);

  a_r7_one_direction: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $countones({cmd_rd, cmd_wr}) == 1);

  a_r4_recovery_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_sta && cmd_sto) |-> (cmd_wr && cmd_byte == 8'h00));

  a_r5_read_no_start: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_rd) |-> !cmd_sta);

  a_r6_nack_reads_only: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_nack) |-> cmd_rd);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind i2cs_seq i2cs_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .cmd_valid(cmd_valid),
  .cmd_sta  (cmd_sta),
  .cmd_sto  (cmd_sto),
  .cmd_rd   (cmd_rd),
  .cmd_wr   (cmd_wr),
  .cmd_nack (cmd_nack),
  .cmd_byte (cmd_byte),
  .core_tip (core_tip)
);

// File: tb/tb_i2cs_seq.sv
`timescale 1ns/1ps
module tb_i2cs_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] msg_count = 4'd1;
  logic [15:0] tmo_limit = 16'd50;
  logic       busy, done, buf_rwe, cmd_valid;
  logic [1:0] status;
  logic [3:0] result_idx, desc_idx;
  logic [7:0] buf_pos, buf_rdata, cmd_byte, buf_wdata;
  logic       cmd_sta, cmd_sto, cmd_rd, cmd_wr, cmd_nack;
  logic       core_tip = 1'b0, core_rxack = 1'b0, core_al = 1'b0;
  logic [7:0] core_rdata = 8'h00;

  logic [6:0] m_addr [16];
  logic       m_rd [16], m_ns [16], m_rev [16];
  logic [7:0] m_len [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign buf_wdata = 8'h40 + {desc_idx, buf_pos[3:0]};

  i2cs_seq dut (
    .clk(clk), .rst(rst), .start(start), .msg_count(msg_count), .tmo_limit(tmo_limit),
    .busy(busy), .done(done), .status(status), .result_idx(result_idx),
    .desc_idx(desc_idx), .desc_addr(m_addr[desc_idx]), .desc_read(m_rd[desc_idx]),
    .desc_nostart(m_ns[desc_idx]), .desc_revdir(m_rev[desc_idx]), .desc_len(m_len[desc_idx]),
    .buf_pos(buf_pos), .buf_wdata(buf_wdata), .buf_rwe(buf_rwe), .buf_rdata(buf_rdata),
    .cmd_valid(cmd_valid), .cmd_sta(cmd_sta), .cmd_sto(cmd_sto), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .cmd_nack(cmd_nack), .cmd_byte(cmd_byte),
    .core_tip(core_tip), .core_rxack(core_rxack), .core_al(core_al), .core_rdata(core_rdata)
  );

  // Master core model and logs
  logic [12:0] clog [256];
  logic [7:0]  rpos [256], rdat [256];
  int nlog = 0, nrd = 0, addr_seen = 0, done_cnt = 0, cnt = 0;
  int addr_base = 0, addr_fail_n = 0;
  logic nack_data = 0, rxack_rd = 0, al_rd = 0, hang = 0;
  logic is_addr;

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (buf_rwe) begin
      rpos[nrd[7:0]] <= buf_pos;
      rdat[nrd[7:0]] <= buf_rdata;
      nrd <= nrd + 1;
    end
    if (cmd_valid) begin
      is_addr = cmd_sta && !cmd_sto;
      clog[nlog[7:0]] <= {cmd_sta, cmd_sto, cmd_rd, cmd_wr, cmd_nack, cmd_byte};
      nlog <= nlog + 1;
      core_tip <= 1'b1;
      cnt <= 2;
      core_rxack <= (cmd_wr && ((is_addr && (addr_seen - addr_base) < addr_fail_n) ||
                                (!cmd_sta && nack_data))) || (cmd_rd && rxack_rd);
      core_al <= cmd_rd && al_rd;
      core_rdata <= 8'hC0 + nlog[7:0];
      if (is_addr) addr_seen <= addr_seen + 1;
    end else if (core_tip && !hang) begin
      if (cnt == 0) core_tip <= 1'b0;
      else cnt <= cnt - 1;
    end
  end

  int n_chk = 0, n_fail = 0, base = 0, rbase = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] enc(input bit sta, input bit sto, input bit rd,
                                      input bit wr, input bit nk, input logic [7:0] b);
    return {sta, sto, rd, wr, nk, b};
  endfunction
  function automatic logic [12:0] c_addr(input logic [7:0] b); return enc(1,0,0,1,0,b); endfunction
  function automatic logic [12:0] c_wr(input logic [7:0] b, input bit sto); return enc(0,sto,0,1,0,b); endfunction
  function automatic logic [12:0] c_rd(input bit nk, input bit sto); return enc(0,sto,1,0,nk,8'h00); endfunction
  function automatic logic [12:0] c_rec(); return enc(1,1,0,1,0,8'h00); endfunction

  task automatic cmd_is(input int i, input logic [12:0] exp, input string req);
    chk(clog[(base + i) % 256] == exp, req, clog[(base + i) % 256], exp);
  endtask

  task automatic set_msg(input int i, input logic [6:0] a, input bit rd, input bit ns,
                         input bit rev, input logic [7:0] len);
    m_addr[i] = a; m_rd[i] = rd; m_ns[i] = ns; m_rev[i] = rev; m_len[i] = len;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    if (!done) chk(0, "watchdog done", 0, 1);
  endtask

  task automatic run(input logic [3:0] n);
    @(negedge clk);
    base = nlog; rbase = nrd; addr_base = addr_seen;
    msg_count = n; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    repeat (12) @(negedge clk);
  endtask

  // {addr7, rd, rev, expected address byte}
  localparam logic [16:0] AVEC [4] = '{
    {7'h50, 1'b0, 1'b0, 8'hA0},
    {7'h50, 1'b1, 1'b0, 8'hA1},
    {7'h3C, 1'b0, 1'b1, 8'h79},
    {7'h7F, 1'b1, 1'b1, 8'hFE}
  };

  initial begin
    for (int i = 0; i < 16; i++) set_msg(i, 7'h00, 0, 0, 0, 8'd0);
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog global", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0 && cmd_valid == 0, "R10 reset outputs", {busy, done, cmd_valid}, 0);
    chk(status == 2'd0, "R10 reset status", status, 0);

    // R1 address byte table
    for (int v = 0; v < 4; v++) begin
      set_msg(0, AVEC[v][16:10], AVEC[v][9], 0, AVEC[v][8], 8'd1);
      run(4'd1);
      cmd_is(0, c_addr(AVEC[v][7:0]), "R1 address byte");
    end

    // Write then read, R5 R6
    set_msg(0, 7'h50, 0, 0, 0, 8'd2);
    set_msg(1, 7'h50, 1, 0, 0, 8'd2);
    run(4'd2);
    chk(nlog - base == 6, "R5 command count", nlog - base, 6);
    cmd_is(0, c_addr(8'hA0), "R3 address with start");
    cmd_is(1, c_wr(8'h40, 0), "R5 write byte 0");
    cmd_is(2, c_wr(8'h41, 0), "R5 no stop before last message");
    cmd_is(3, c_addr(8'hA1), "R1 read address");
    cmd_is(4, c_rd(0, 0), "R6 ack non-last read");
    cmd_is(5, c_rd(1, 1), "R6 nack and stop last");
    chk(nrd - rbase == 2, "R6 read count", nrd - rbase, 2);
    chk(rpos[rbase % 256] == 0 && rdat[rbase % 256] == 8'(8'hC0 + base + 4), "R6 read byte 0",
        rdat[rbase % 256], 8'(8'hC0 + base + 4));
    chk(rpos[(rbase + 1) % 256] == 1 && rdat[(rbase + 1) % 256] == 8'(8'hC0 + base + 5),
        "R6 read byte 1", rdat[(rbase + 1) % 256], 8'(8'hC0 + base + 5));
    chk(status == 0 && result_idx == 1, "R10 success index", {status, result_idx}, 1);

    // R2 skip-address message
    set_msg(0, 7'h22, 0, 0, 0, 8'd1);
    set_msg(1, 7'h22, 0, 1, 0, 8'd1);
    run(4'd2);
    chk(nlog - base == 3, "R2 command count", nlog - base, 3);
    cmd_is(1, c_wr(8'h40, 0), "R2 first message data");
    cmd_is(2, c_wr(8'h50, 1), "R2 no-start data with stop");

    // R12 zero-length last message
    set_msg(1, 7'h23, 0, 0, 0, 8'd0);
    run(4'd2);
    chk(nlog - base == 3, "R12 command count", nlog - base, 3);
    cmd_is(2, c_addr(8'h46), "R12 address only, no stop");
    chk(status == 0 && result_idx == 1, "R12 status", {status, result_idx}, 1);

    // R3 retry succeeds after two failures
    set_msg(0, 7'h10, 0, 0, 0, 8'd1);
    addr_fail_n = 2;
    run(4'd1);
    chk(nlog - base == 6, "R3 retry count", nlog - base, 6);
    cmd_is(1, c_rec(), "R4 recovery after failed address");
    cmd_is(4, c_addr(8'h20), "R3 third attempt");
    cmd_is(5, c_wr(8'h40, 1), "R3 data after retry");
    chk(status == 0, "R3 retry ok", status, 0);

    // R3 three failures
    addr_fail_n = 3;
    run(4'd1);
    chk(nlog - base == 6, "R3 give-up count", nlog - base, 6);
    cmd_is(5, c_rec(), "R3 recovery after last attempt");
    chk(status == 1, "R3 IO error", status, 1);
    repeat (10) @(negedge clk);
    chk(status == 1 && result_idx == 0 && !busy, "R11 status held", status, 1);
    addr_fail_n = 0;

    // R8 write nack aborts
    set_msg(0, 7'h10, 0, 0, 0, 8'd2);
    nack_data = 1;
    run(4'd1);
    nack_data = 0;
    chk(nlog - base == 3, "R8 write abort count", nlog - base, 3);
    cmd_is(2, c_rec(), "R8 recovery on write nack");
    chk(status == 1, "R8 write nack status", status, 1);

    // R8 read ignores missing ack
    set_msg(0, 7'h10, 1, 0, 0, 8'd2);
    rxack_rd = 1;
    run(4'd1);
    rxack_rd = 0;
    chk(nlog - base == 3 && status == 0, "R8 read rxack ignored", status, 0);
    chk(nrd - rbase == 2, "R8 reads delivered", nrd - rbase, 2);

    // R8 read arbitration loss aborts
    al_rd = 1;
    run(4'd1);
    al_rd = 0;
    chk(nlog - base == 3, "R8 read al count", nlog - base, 3);
    cmd_is(2, c_rec(), "R8 recovery on read al");
    chk(status == 1 && nrd == rbase, "R8 read al status", status, 1);

    // R9 timeout
    set_msg(0, 7'h10, 0, 0, 0, 8'd1);
    tmo_limit = 16'd20;
    hang = 1;
    run(4'd1);
    chk(status == 2, "R9 timeout status", status, 2);
    chk(nlog - base == 1, "R9 no recovery", nlog - base, 1);
    hang = 0;
    tmo_limit = 16'd50;
    repeat (10) @(negedge clk);

    // R11 start ignored while busy
    set_msg(0, 7'h50, 0, 0, 0, 8'd2);
    set_msg(1, 7'h50, 1, 0, 0, 8'd2);
    begin
      int d0;
      d0 = done_cnt;
      @(negedge clk);
      base = nlog;
      msg_count = 4'd2; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (8) @(negedge clk);
      chk(busy == 1, "R11 busy mid-run", busy, 1);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      chk(nlog - base == 6, "R11 no restart commands", nlog - base, 6);
      chk(done_cnt - d0 == 1, "R11 single done", done_cnt - d0, 1);
      chk(status == 0 && result_idx == 1, "R11 result", {status, result_idx}, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule